// File: doc/BRIEF.md
# Banked Host Register Window Decoder

This block sits between a host I/O bus and a small register file that is split into eight banks. It captures the host address, the address-enable qualifier and the four active-low byte enables in a transparent latch that closes when the address strobe rises. It compares address bits 15..4 with a programmable I/O base and, when the cycle is a plain I/O cycle (AEN low) inside the 16-byte window, pulls its local-device indication low.

Inside the window the low address bits and byte enables become one strobe per byte offset. A three-bit bank select register lives at the top of the window and can be reached from every bank; it decides which bank the other offsets belong to. Bank 7 is not backed by internal registers. When it is selected, a matching cycle drives an external chip select low, writes to internal offsets are dropped and the read data enable stays off. The I/O base itself is kept in bank 1 so that software can move the window.

Top module: `host_bank_decoder`

## Requirements
- R1: The address, AEN and byte enables follow the inputs while `ads_n` is low and hold their value from the rising edge of `ads_n` until it falls again.
- R2: `dev_hit_n` is low exactly when the held AEN is 0 and the held address bits 15..4 equal the programmed I/O base.
- R3: The I/O base resets to 0x300. It is held in bank 1 at byte offsets 2 and 3: offset 3 carries base bits 12..5, offset 2 carries base bits 15..13 in bits 2..0 and base bit 4 in bit 3 (bits 7..4 read 0). Reset values read back as 0x00 (offset 2) and 0x18 (offset 3). Writing these bytes in bank 1 moves the window.
- R4: The bank select register sits at byte offset 0xE in every bank. Its low 3 bits hold the bank and reset to 0; the other bits of offset 0xE read 0, and offset 0xF reads the constant 0x33. Offsets 0xE and 0xF never raise a bank strobe, and the bank only changes on a write cycle.
- R5: A write with all four byte enables active at a dword address of 0xC (A3..A1 = 110) loads the bank select from data bits 23..16 and raises no write strobe for offsets 0xC and 0xD. A single-byte write to 0xC does raise its strobe.
- R6: With bank 7 selected, a matching cycle drives `ext_cs_n` low, all read and write strobes stay low, writes to internal offsets change nothing, and `rdata_oe` stays low unless offset 0xE or 0xF is accessed. `ext_cs_n` is high whenever the cycle does not match.
- R7: Byte lane mapping: with A1 = 0, active byte enable k selects offset {A3,A2,k}. With A1 = 1 (16-bit host), byte enable 0 and 1 select offsets {A3,A2,1,0} and {A3,A2,1,1}; byte enables 3 and 2 are ignored.
- R8: `wr_stb[o]` / `rd_stb[o]` are high only while the cycle matches, the internal bank is selected, the write / read strobe is low and offset o is accessed.
- R9: Read data: with A1 = 0, lane k (`rdata` bits 8k+7..8k) carries offset {A3,A2,k}; with A1 = 1, `rdata[15:0]` carries the two bytes of the addressed half-word and bits 31..16 are 0. Offsets without a register inside this block read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank and base registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | 15 | Host address bits 15..1 |
| aen_in | input | 1 | Address enable qualifier, 0 for an I/O cycle to this block |
| be_n_in | input | 4 | Active-low byte enables |
| ads_n | input | 1 | Address strobe; latch is open while low |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 32 | Host write data |
| dev_hit_n | output | 1 | Active-low local-device indication |
| bank_o | output | 3 | Currently selected bank |
| wr_stb | output | 16 | Per byte offset write strobes into the selected bank |
| rd_stb | output | 16 | Per byte offset read strobes into the selected bank |
| ext_cs_n | output | 1 | Active-low external chip select for bank 7 |
| rdata | output | 32 | Read data for the registers held here |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
On every clock the assertions check the relations that need no history: an external select only under a match, no strobe of any kind while bank 7 owns the window, no strobe for the bank select offsets, no match with AEN high, no strobe without its bus strobe, no loss of offsets 0xC/0xD suppression on a dword write, and a bank that holds still outside write cycles. What only the bench scenarios can show is the arithmetic: the full sweep of base compares against a moving base, the latch holding across an address change, the exact lane-to-offset map over every address and enable pattern, the read-back values, and that a dropped bank-7 write really left the base untouched.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  localparam int WIN_BYTES = 16;
  localparam int OFF_W     = 4;

  // Byte offsets of the window touched by a host cycle.
  function automatic logic [WIN_BYTES-1:0] lane_mask(input logic [3:1] a,
                                                     input logic [3:0] be_n);
    logic [WIN_BYTES-1:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) begin
      if (!be_n[k]) begin
        if (a[1]) begin
          if (k < 2) m[{a[3:2], 1'b1, k[0]}] = 1'b1;
        end else begin
          m[{a[3:2], k[1:0]}] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  // Byte of the data bus that carries a given offset.
  function automatic logic [7:0] lane_byte(input logic [31:0] d,
                                           input logic        a1,
                                           input logic [1:0]  lo);
    logic [7:0] b;
    if (a1) begin
      b = lo[0] ? d[15:8] : d[7:0];
    end else begin
      case (lo)
        2'd0:    b = d[7:0];
        2'd1:    b = d[15:8];
        2'd2:    b = d[23:16];
        default: b = d[31:24];
      endcase
    end
    return b;
  endfunction

  // Stored base register to compare value for address bits 15..4.
  function automatic logic [15:4] base_field(input logic [15:0] r);
    return {r[2:0], r[15:8], r[3]};
  endfunction

endpackage

// File: rtl/hbd_addr_latch.sv
module hbd_addr_latch #(
  parameter int AW = 15,
  parameter int BW = 4
) (
  input  logic          ads_n,
  input  logic [AW:1]   a_in,
  input  logic          aen_in,
  input  logic [BW-1:0] be_n_in,
  output logic [AW:1]   a_q,
  output logic          aen_q,
  output logic [BW-1:0] be_n_q
);

  // Open while the strobe is low, closed from its rising edge.
  always_latch begin
    if (!ads_n) begin
      a_q    = a_in;
      aen_q  = aen_in;
      be_n_q = be_n_in;
    end
  end

endmodule

// File: rtl/hbd_base_match.sv
module hbd_base_match (
  input  logic [15:4] a_hi,
  input  logic        aen,
  input  logic [15:0] base_reg,
  output logic        hit
);
  import hbd_pkg::*;

  logic [15:4] base_cmp;

  assign base_cmp = base_field(base_reg);
  assign hit      = !aen && (a_hi == base_cmp);

endmodule

// File: rtl/hbd_lane_decode.sv
module hbd_lane_decode #(
  parameter int BANK_W   = 3,
  parameter int BSEL_OFF = 14
) (
  input  logic [3:1]        a,
  input  logic [3:0]        be_n,
  input  logic              hit,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BANK_W-1:0] bank,
  output logic [15:0]       acc_mask,
  output logic              dword_low,
  output logic [15:0]       wr_stb,
  output logic [15:0]       rd_stb
);
  import hbd_pkg::*;

  localparam int                NBANK    = 1 << BANK_W;
  localparam logic [BANK_W-1:0] EXT_BANK = BANK_W'(NBANK - 1);
  localparam int                DW_LO    = BSEL_OFF - 2;

  logic internal_ok;

  assign acc_mask    = lane_mask(a, be_n);
  assign dword_low   = (acc_mask[DW_LO +: 4] == 4'hF);
  assign internal_ok = hit && (bank != EXT_BANK);

  for (genvar o = 0; o < WIN_BYTES; o++) begin : g_off
    localparam bit IS_TOP = (o >= BSEL_OFF);
    localparam bit IS_DWL = (o == DW_LO) || (o == DW_LO + 1);
    assign wr_stb[o] = !IS_TOP && internal_ok && !wr_n && acc_mask[o]
                       && !(IS_DWL && dword_low);
    assign rd_stb[o] = !IS_TOP && internal_ok && !rd_n && acc_mask[o];
  end

endmodule

// File: rtl/hbd_cfg_regs.sv
module hbd_cfg_regs #(
  parameter int          BANK_W     = 3,
  parameter int          BASE_BANK  = 1,
  parameter int          BASE_OFF   = 2,
  parameter int          BSEL_OFF   = 14,
  parameter logic [15:0] BASE_RESET = 16'h1800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [15:0]       acc_mask,
  input  logic              a1,
  input  logic [31:0]       wdata,
  output logic [BANK_W-1:0] bank_q,
  output logic [15:0]       base_q
);
  import hbd_pkg::*;

  localparam logic [1:0]        BS_LANE  = 2'(BSEL_OFF % 4);
  localparam logic [1:0]        BL_LANE  = 2'(BASE_OFF % 4);
  localparam logic [1:0]        BH_LANE  = 2'((BASE_OFF + 1) % 4);
  localparam logic [BANK_W-1:0] BASE_BNK = BANK_W'(BASE_BANK);

  logic [7:0] bsel_byte, base_lo_byte, base_hi_byte;
  logic       base_bank_sel;

  assign bsel_byte     = lane_byte(wdata, a1, BS_LANE);
  assign base_lo_byte  = lane_byte(wdata, a1, BL_LANE);
  assign base_hi_byte  = lane_byte(wdata, a1, BH_LANE);
  assign base_bank_sel = (bank_q == BASE_BNK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_act && acc_mask[BSEL_OFF]) begin
      bank_q <= BANK_W'(bsel_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RESET;
    end else if (wr_act && base_bank_sel) begin
      if (acc_mask[BASE_OFF])     base_q[7:0]  <= {4'h0, base_lo_byte[3:0]};
      if (acc_mask[BASE_OFF + 1]) base_q[15:8] <= base_hi_byte;
    end
  end

endmodule

// File: rtl/host_bank_decoder.sv
module host_bank_decoder #(
  parameter int          BANK_W     = 3,
  parameter int          BASE_BANK  = 1,
  parameter int          BASE_OFF   = 2,
  parameter int          BSEL_OFF   = 14,
  parameter logic [15:0] BASE_RESET = 16'h1800,
  parameter logic [7:0]  BSEL_HI    = 8'h33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:1]       addr_in,
  input  logic              aen_in,
  input  logic [3:0]        be_n_in,
  input  logic              ads_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [31:0]       wdata,
  output logic              dev_hit_n,
  output logic [BANK_W-1:0] bank_o,
  output logic [15:0]       wr_stb,
  output logic [15:0]       rd_stb,
  output logic              ext_cs_n,
  output logic [31:0]       rdata,
  output logic              rdata_oe
);
  import hbd_pkg::*;

  localparam int                NBANK    = 1 << BANK_W;
  localparam logic [BANK_W-1:0] EXT_BANK = BANK_W'(NBANK - 1);
  localparam logic [BANK_W-1:0] BASE_BNK = BANK_W'(BASE_BANK);

  // Named internal events, also watched by the checker.
  logic [15:1] lat_addr;
  logic        lat_aen;
  logic [3:0]  lat_be_n;
  logic        win_hit;
  logic [15:0] acc_mask;
  logic        dword_low;
  logic        ext_sel;
  logic [15:0] base_q;
  logic        wr_act;
  logic [7:0]  view [WIN_BYTES];

  hbd_addr_latch #(.AW(15), .BW(4)) u_latch (
    .ads_n   (ads_n),
    .a_in    (addr_in),
    .aen_in  (aen_in),
    .be_n_in (be_n_in),
    .a_q     (lat_addr),
    .aen_q   (lat_aen),
    .be_n_q  (lat_be_n)
  );

  hbd_base_match u_match (
    .a_hi     (lat_addr[15:4]),
    .aen      (lat_aen),
    .base_reg (base_q),
    .hit      (win_hit)
  );

  hbd_lane_decode #(.BANK_W(BANK_W), .BSEL_OFF(BSEL_OFF)) u_lanes (
    .a         (lat_addr[3:1]),
    .be_n      (lat_be_n),
    .hit       (win_hit),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bank      (bank_o),
    .acc_mask  (acc_mask),
    .dword_low (dword_low),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb)
  );

  assign wr_act = win_hit && !wr_n;

  hbd_cfg_regs #(
    .BANK_W     (BANK_W),
    .BASE_BANK  (BASE_BANK),
    .BASE_OFF   (BASE_OFF),
    .BSEL_OFF   (BSEL_OFF),
    .BASE_RESET (BASE_RESET)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_act   (wr_act),
    .acc_mask (acc_mask),
    .a1       (lat_addr[1]),
    .wdata    (wdata),
    .bank_q   (bank_o),
    .base_q   (base_q)
  );

  assign ext_sel   = win_hit && (bank_o == EXT_BANK);
  assign ext_cs_n  = !ext_sel;
  assign dev_hit_n = !win_hit;

  // Byte view of the registers held in this block.
  always_comb begin
    for (int o = 0; o < WIN_BYTES; o++) view[o] = 8'h00;
    view[BSEL_OFF]     = 8'(bank_o);
    view[BSEL_OFF + 1] = BSEL_HI;
    if (bank_o == BASE_BNK) begin
      view[BASE_OFF]     = base_q[7:0];
      view[BASE_OFF + 1] = base_q[15:8];
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_rd_lane
    logic [3:0] off_k;
    assign off_k = lat_addr[1] ? {lat_addr[3:2], 1'b1, 1'(k % 2)}
                               : {lat_addr[3:2], 2'(k)};
    if (k < 2) begin : g_lo
      assign rdata[8*k +: 8] = view[off_k];
    end else begin : g_hi
      assign rdata[8*k +: 8] = lat_addr[1] ? 8'h00 : view[off_k];
    end
  end

  assign rdata_oe = win_hit && !rd_n
                    && (!ext_sel || (acc_mask[BSEL_OFF +: 2] != 2'b00));

endmodule

// File: rtl/host_bank_decoder_chk.sv
module host_bank_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        dev_hit_n,
  input logic        ext_cs_n,
  input logic [15:0] wr_stb,
  input logic [15:0] rd_stb,
  input logic [2:0]  bank_o,
  input logic        lat_aen,
  input logic [15:1] lat_addr,
  input logic [3:0]  lat_be_n
);

  // R6
  ext_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cs_n |-> !dev_hit_n);

  // R6
  ext_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cs_n |-> (wr_stb == 16'h0 && rd_stb == 16'h0));

  // R4
  top_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[15:14] == 2'b00) && (rd_stb[15:14] == 2'b00));

  // R5
  dword_c_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_addr[3:1] == 3'b110 && lat_be_n == 4'h0) |-> (wr_stb[13:12] == 2'b00));

  // R2
  aen_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_hit_n |-> !lat_aen);

  // R8
  no_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |-> (wr_stb == 16'h0));

  // R8
  no_rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (rd_stb == 16'h0));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(bank_o));

endmodule

bind host_bank_decoder host_bank_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .dev_hit_n (dev_hit_n),
  .ext_cs_n  (ext_cs_n),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .bank_o    (bank_o),
  .lat_aen   (lat_aen),
  .lat_addr  (lat_addr),
  .lat_be_n  (lat_be_n)
);

// File: tb/host_bank_decoder_test.sv
module host_bank_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] addr_in = '0;
  logic        aen_in = 1'b1;
  logic [3:0]  be_n_in = 4'hF;
  logic        ads_n = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [31:0] wdata = '0;
  logic        dev_hit_n;
  logic [2:0]  bank_o;
  logic [15:0] wr_stb, rd_stb;
  logic        ext_cs_n;
  logic [31:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] cur_base = 16'h0300;
  logic [15:0] s_wr, s_rd;
  logic [31:0] s_rdata;
  logic        s_oe, s_ext;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_bank_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .aen_in(aen_in),
    .be_n_in(be_n_in), .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .dev_hit_n(dev_hit_n), .bank_o(bank_o),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .ext_cs_n(ext_cs_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offsets a cycle should touch, worked out per offset.
  function automatic logic [15:0] want_mask(input logic [3:1] a, input logic [3:0] ben);
    logic [15:0] m = '0;
    for (int o = 0; o < 16; o++) begin
      if (a[1] == 1'b0)
        m[o] = ((o / 4) == int'(a[3:2])) && !ben[o % 4];
      else
        m[o] = ((o / 2) == int'(a[3:2]) * 2 + 1) && !ben[o % 2];
    end
    return m;
  endfunction

  function automatic logic [15:0] base_bytes(input logic [15:0] a);
    return {a[12:5], 4'h0, a[4], a[15:13]};
  endfunction

  function automatic logic [15:0] win(input logic [3:0] off);
    return {cur_base[15:4], off};
  endfunction

  task automatic put_addr(input logic [15:0] a, input logic aen, input logic [3:0] ben);
    addr_in = a[15:1];
    aen_in  = aen;
    be_n_in = ben;
    ads_n   = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [3:0] ben, input logic [31:0] d);
    @(negedge clk);
    put_addr(a, 1'b0, ben);
    wdata = d;
    wr_n  = 1'b0;
    #1;
    s_wr  = wr_stb;
    s_ext = ext_cs_n;
    @(negedge clk);
    wr_n = 1'b1;
    #1;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [3:0] ben);
    @(negedge clk);
    put_addr(a, 1'b0, ben);
    rd_n = 1'b0;
    #1;
    s_rd    = rd_stb;
    s_rdata = rdata;
    s_oe    = rdata_oe;
    s_ext   = ext_cs_n;
    @(negedge clk);
    rd_n = 1'b1;
    #1;
  endtask

  task automatic sweep_base(input string req);
    for (int h = 0; h < 4096; h++) begin
      for (int e = 0; e < 2; e++) begin
        put_addr({h[11:0], 4'h0}, e[0], 4'hF);
        #1;
        chk(req, {31'd0, dev_hit_n},
            {31'd0, !((e == 0) && (h[11:0] == cur_base[15:4]))});
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: reset state
    chk("R4 reset bank", {29'd0, bank_o}, 32'd0);
    bus_rd(win(4'hE), 4'b1100);
    chk("R4 reset bank select read", s_rdata, 32'h0000_3300);
    chk("R9 reset read enable", {31'd0, s_oe}, 32'd1);

    // R2: full base compare sweep with reset base
    sweep_base("R2 reset base sweep");

    // R1: latch holds after the strobe rises
    put_addr(16'h0300, 1'b0, 4'hF);
    #1;
    ads_n = 1'b1;
    #1;
    put_addr(16'h0310, 1'b1, 4'hF);
    ads_n = 1'b1;
    #1;
    chk("R1 held match", {31'd0, dev_hit_n}, 32'd0);
    ads_n = 1'b0;
    #1;
    chk("R1 reopened", {31'd0, dev_hit_n}, 32'd1);

    // R3: select bank 1 and read the base reset value
    bus_wr(win(4'hE), 4'b1100, 32'h0000_0001);
    chk("R4 bank select write", {29'd0, bank_o}, 32'd1);
    bus_rd(win(4'h2), 4'b1100);
    chk("R3 base reset bytes", s_rdata, 32'h0000_1800);

    // R3: move the window
    bus_wr(win(4'h2), 4'b1100, {16'h0, base_bytes(16'hE750)});
    cur_base = 16'hE750;
    bus_rd(win(4'h2), 4'b1100);
    chk("R3 base read back", s_rdata, {16'h0, base_bytes(16'hE750)});
    sweep_base("R2 moved base sweep");

    // R7 R8 R9: lane mapping sweep in bank 1
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 16; b++) begin
        bus_rd({cur_base[15:4], a[2:0], 1'b0}, b[3:0]);
        chk("R7 read lanes", {16'h0, s_rd}, {16'h0, want_mask(a[2:0], b[3:0]) & 16'h3FFF});
      end
    end

    // R9: dword read at 0xC shows bank select in lane 2
    bus_rd(win(4'hC), 4'h0);
    chk("R9 dword read 0xC", s_rdata, 32'h3301_0000);

    // R8: no strobes outside the window
    @(negedge clk);
    put_addr(16'h0300, 1'b0, 4'h0);
    rd_n = 1'b0;
    #1;
    chk("R8 miss no strobe", {16'h0, rd_stb}, 32'h0);
    chk("R8 miss no enable", {31'd0, rdata_oe}, 32'h0);
    rd_n = 1'b1;

    // R5: single byte at 0xC strobes, dword at 0xC does not
    bus_wr(win(4'hC), 4'b1110, 32'h0000_00AA);
    chk("R5 byte write 0xC", {16'h0, s_wr}, 32'h0000_1000);
    bus_wr(win(4'hC), 4'h0, 32'h0002_5566);
    chk("R5 dword write strobes", {16'h0, s_wr}, 32'h0);
    chk("R5 dword write bank", {29'd0, bank_o}, 32'd2);
    bus_wr(win(4'h8), 4'h0, 32'h1234_5678);
    chk("R8 dword write 0x8", {16'h0, s_wr}, 32'h0000_0F00);

    // R6: bank 7
    bus_wr(win(4'hE), 4'b1100, 32'h0000_0007);
    chk("R6 bank 7 selected", {29'd0, bank_o}, 32'd7);
    bus_wr(win(4'h2), 4'b1100, 32'h0000_FFFF);
    chk("R6 bank 7 write strobes", {16'h0, s_wr}, 32'h0);
    chk("R6 bank 7 ext select", {31'd0, s_ext}, 32'd0);
    bus_rd(win(4'h0), 4'h0);
    chk("R6 bank 7 read enable", {31'd0, s_oe}, 32'd0);
    chk("R6 bank 7 read strobes", {16'h0, s_rd}, 32'h0);
    bus_rd(win(4'hE), 4'b1100);
    chk("R6 bank 7 bank select read", {s_oe, s_rdata[30:0]}, 32'h8000_3307);
    put_addr(16'h0300, 1'b0, 4'hF);
    #1;
    chk("R6 miss ext high", {31'd0, ext_cs_n}, 32'd1);
    put_addr(win(4'h0), 1'b1, 4'hF);
    #1;
    chk("R6 aen ext high", {31'd0, ext_cs_n}, 32'd1);

    // R6: the dropped write left the base unchanged
    bus_wr(win(4'hE), 4'b1100, 32'h0000_0001);
    bus_rd(win(4'h2), 4'b1100);
    chk("R6 base untouched", s_rdata, {16'h0, base_bytes(16'hE750)});
    chk("R4 no change on read", {29'd0, bank_o}, 32'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule